// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the slave side of a two-wire serial memory. It watches the clock and data lines after resynchronising them to the system clock. It finds START and STOP conditions and shifts in the select, address and data bytes. It acknowledges a byte by pulling the data line low through an open-drain enable.

One device code covers three storage targets: the main 4096x8 array, a 32-byte one-time page and an 8-bit control register. The engine runs byte and page writes, and current, random and sequential reads. Storage sits behind a simple port that the engine drives. An outside protection block looks at the target and address that the engine presents and says whether a data byte may be written.

Written bytes are collected in a row buffer. They reach storage only during the internal write cycle. That cycle is a counter that keeps the engine off the bus, so a master can poll for the acknowledge.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A select byte is acknowledged only when its top four bits are 1010 and its target bits [3:1] are 000 (main array, `mem_sel`=0), 001 (one-time page, `mem_sel`=1) or 100 (control register, `mem_sel`=2). Any other select is not acknowledged, and the bytes that follow are ignored until the next START.
- R2: After a write select (bit 0 = 0), two address bytes arrive high byte first and are both acknowledged. Only the low 12 bits of the 16-bit address are used.
- R3: START is a falling data line while the clock is high. Outside the write cycle, it aborts any transfer and restarts select decoding, and bytes buffered before it are dropped.
- R4: An accepted byte is acknowledged by `sda_oe`=1 during the 9th clock only. After reset, `sda_oe` is 0.
- R5: A write cycle starts only when STOP (a rising data line while the clock is high) arrives in the clock slot right after an acknowledge, and at least one data byte has been accepted. A STOP anywhere else writes nothing.
- R6: While the write cycle runs (`BUSY_CYCLES` clocks), no select is acknowledged. After it ends, a select is acknowledged again.
- R7: The write cycle stores the accepted bytes in order. The first goes at the loaded address, and each next one at the following address, with the low 5 bits wrapping inside the same 32-byte row.
- R8: A write transaction accepts at most 32 data bytes. Later data bytes are not acknowledged and not stored.
- R9: When `wr_allow` is 0 for a data byte, that byte is neither acknowledged nor stored, while the select and address bytes are still acknowledged.
- R10: A read select (bit 0 = 1) returns the byte at the internal address counter, which then advances. The counter uses all 12 bits for the main array and wraps within 5 bits for the one-time page.
- R11: In a random read, an address write is followed by a repeated START and a read select. If the upper seven bits of the two selects differ, the read select is not acknowledged.
- R12: After each read byte, a master acknowledge continues with the next byte. A master non-acknowledge releases the data line and sends the engine to standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull data line low when 1 |
| mem_sel | output | 2 | Storage target: 0 array, 1 one-time page, 2 control register |
| mem_addr | output | 12 | Storage address for reads, protection queries and writes |
| mem_rdata | input | 8 | Storage read data for `mem_sel`/`mem_addr` |
| mem_we | output | 1 | Storage write strobe |
| mem_wdata | output | 8 | Storage write data |
| wr_allow | input | 1 | Protection answer for the presented target and address |

## Verification
The bench builds the engine with `BUSY_CYCLES` = 400 and keeps the other parameters at their defaults. With that value, a master poll sent right after a programming STOP falls inside the write cycle. The bench can then wait out the cycle and confirm that the select is acknowledged again. The row wrap, the 32-byte cap and the one-time page wrap all come from the default row size, so a full 33-byte page write is part of the run.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int ADDR_W      = 12,
  parameter int PAGE        = 32,
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [1:0]        mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic              wr_allow
);
  localparam int PW = $clog2(PAGE);
  localparam int NW = PW + 1;
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD, S_BUSY} st_t;

  st_t               st;
  logic [1:0]        scl_q, sda_q;
  logic              scl_p, sda_p;
  logic [3:0]        bitcnt;
  logic [7:0]        sh, ahi, dout;
  logic [6:0]        psel;
  logic              mack, dummy;
  logic [ADDR_W-1:0] addr, wstart, addr_nx;
  logic [NW-1:0]     nbytes, ptr;
  logic [CW-1:0]     bcnt;
  logic [7:0]        pbuf [PAGE];
  logic              sel_ok;
  logic [1:0]        sel_t;
  logic [15:0]       full;

  wire scl_s    = scl_q[1];
  wire sda_s    = sda_q[1];
  wire rise     = scl_s & ~scl_p;
  wire fall     = ~scl_s & scl_p;
  wire start_ev = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  wire take     = (st == S_WR) && fall && (bitcnt == 4'd8) && wr_allow && (nbytes < NW'(PAGE));

  assign full      = {ahi, sh};
  assign mem_sel   = (st == S_IDLE || st == S_DEV) ? sel_t : mem_sel_q;
  logic [1:0] mem_sel_q;
  assign mem_addr  = (st == S_BUSY) ? {wstart[ADDR_W-1:PW], wstart[PW-1:0] + ptr[PW-1:0]} : addr;
  assign mem_we    = (st == S_BUSY) && (ptr < nbytes);
  assign mem_wdata = pbuf[ptr[PW-1:0]];
  assign addr_nx   = (mem_sel_q == 2'd1) ? {addr[ADDR_W-1:PW], addr[PW-1:0] + 1'b1} : addr + 1'b1;

  always_comb begin
    sel_ok = (sh[7:4] == 4'b1010);
    sel_t  = 2'd0;
    case (sh[3:1])
      3'b000:  sel_t = 2'd0;
      3'b001:  sel_t = 2'd1;
      3'b100:  sel_t = 2'd2;
      default: sel_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 2'b11; sda_q <= 2'b11; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i}; sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_s;             sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk)
    if (take) pbuf[nbytes[PW-1:0]] <= sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sh <= '0; ahi <= '0; dout <= '0; psel <= '0;
      mack <= 1'b1; dummy <= 1'b0; addr <= '0; wstart <= '0; nbytes <= '0;
      ptr <= '0; bcnt <= '0; sda_oe <= 1'b0; mem_sel_q <= 2'd0;
    end else if (st == S_BUSY) begin
      if (ptr < nbytes) ptr <= ptr + 1'b1;
      if (bcnt == '0) st <= S_IDLE;
      else bcnt <= bcnt - 1'b1;
    end else if (start_ev) begin
      st <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      sda_oe <= 1'b0; dummy <= 1'b0;
      if (st == S_WR && bitcnt == 4'd1 && nbytes != '0) begin
        st <= S_BUSY; bcnt <= CW'(BUSY_CYCLES - 1); ptr <= '0;
      end else st <= S_IDLE;
    end else if (st != S_IDLE) begin
      if (rise) begin
        if (bitcnt < 4'd8) begin
          sh <= {sh[6:0], sda_s}; bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == 4'd9) mack <= sda_s;
      end
      if (fall) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9; sda_oe <= 1'b0;
          case (st)
            S_DEV: if (sel_ok && !(sh[0] && dummy && sh[7:1] != psel)) begin
              sda_oe <= 1'b1; mem_sel_q <= sel_t; dummy <= 1'b0;
              if (sh[0]) st <= S_RD;
              else begin st <= S_AHI; psel <= sh[7:1]; nbytes <= '0; end
            end else begin
              st <= S_IDLE; dummy <= 1'b0;
            end
            S_AHI: begin sda_oe <= 1'b1; ahi <= sh; st <= S_ALO; end
            S_ALO: begin
              sda_oe <= 1'b1; addr <= full[ADDR_W-1:0]; wstart <= full[ADDR_W-1:0];
              dummy <= 1'b1; st <= S_WR;
            end
            S_WR: if (take) begin
              sda_oe <= 1'b1; nbytes <= nbytes + 1'b1;
              addr <= {addr[ADDR_W-1:PW], addr[PW-1:0] + 1'b1};
            end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0; sda_oe <= 1'b0;
          if (st == S_RD) begin
            if (!mack) begin
              dout <= mem_rdata; sda_oe <= ~mem_rdata[7]; addr <= addr_nx;
            end else st <= S_IDLE;
          end
        end else if (st == S_RD && bitcnt != 4'd0) begin
          sda_oe <= ~dout[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end

  assert_ack_in_ninth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && st != S_RD) |-> bitcnt == 4'd9);
  assert_quiet_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY) |-> !sda_oe);
  assert_page_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nbytes <= NW'(PAGE));
  assert_program_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && $past(st) != S_BUSY) |-> $past(stop_ev));
  assert_start_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && st != S_BUSY) |=> (st == S_DEV && bitcnt == 4'd0));
endmodule

// File: tb/eeprom_i2c_slave_test.sv
module eeprom_i2c_slave_test;
  localparam int BUSY = 400;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic allow = 1'b1;
  logic sda_oe, mem_we;
  logic [1:0] mem_sel;
  logic [11:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;
  wire bus = m_sda & ~sda_oe;

  logic [7:0] arr [4096];
  logic [7:0] otp [32];
  logic [7:0] creg;
  logic [21:0] expq [$];
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  eeprom_i2c_slave #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus), .sda_oe(sda_oe),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .wr_allow(allow));

  initial begin
    for (int i = 0; i < 4096; i++) arr[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 32; i++) otp[i] = 8'hFF;
    creg = 8'h00;
  end

  always_comb
    case (mem_sel)
      2'd0:    mem_rdata = arr[mem_addr];
      2'd1:    mem_rdata = otp[mem_addr[4:0]];
      default: mem_rdata = creg;
    endcase

  always @(posedge clk)
    if (mem_we)
      case (mem_sel)
        2'd0:    arr[mem_addr] <= mem_wdata;
        2'd1:    otp[mem_addr[4:0]] <= mem_wdata;
        default: creg <= mem_wdata;
      endcase

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every storage write must match the next expected item (R7)
  always @(negedge clk)
    if (rst_n && mem_we) begin
      if (expq.size() == 0) chk(0, "R7/R5 unexpected write", {mem_sel, mem_addr, mem_wdata}, 0);
      else begin
        logic [21:0] e;
        e = expq.pop_front();
        chk({mem_sel, mem_addr, mem_wdata} == e, "R7 write item", {mem_sel, mem_addr, mem_wdata}, e);
      end
    end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input [1:0] s, input [11:0] a, input [7:0] d);
    expq.push_back({s, a, d});
  endtask

  task automatic start_c();
    m_sda = 1'b1; tick(H/2); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H/2);
  endtask

  task automatic stop_c();
    tick(H/2); m_sda = 1'b0; tick(H/2); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic send_bits(input [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte(input [7:0] b, output bit ack);
    send_bits(b, 8);
    tick(H/2); m_sda = 1'b1; tick(H/2); m_scl = 1'b1; tick(H/2);
    ack = !bus;
    tick(H/2); m_scl = 1'b0; tick(H/2);
  endtask

  task automatic recv_byte(input bit nack, output [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); m_scl = 1'b1; tick(H/2); b[i] = bus; tick(H/2); m_scl = 1'b0;
    end
    tick(H/2); m_sda = nack; tick(H/2); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(H/2); m_sda = 1'b1;
  endtask

  task automatic rand_read(input [7:0] sw, input [15:0] a, output [7:0] d);
    bit k;
    start_c(); send_byte(sw, k); send_byte(a[15:8], k); send_byte(a[7:0], k);
    start_c(); send_byte(sw | 8'h01, k); recv_byte(1'b1, d); stop_c();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    tick(5); rst_n = 1'b1; tick(3);
    chk(sda_oe == 1'b0, "R4 reset sda_oe", sda_oe, 0);
    chk(mem_we == 1'b0, "R4 reset mem_we", mem_we, 0);

    // R1: bad code and bad target
    start_c(); send_byte(8'hB0, a); chk(!a, "R1 wrong code nack", a, 0);
    send_byte(8'hA0, a); chk(!a, "R1 ignored until START", a, 0); stop_c();
    start_c(); send_byte(8'hA4, a); chk(!a, "R1 bad target nack", a, 0); stop_c();

    // R2 R7: page write with row wrap, upper address bits ignored
    start_c(); send_byte(8'hA0, a); chk(a, "R1 array select ack", a, 1);
    send_byte(8'hF1, a); chk(a, "R2 addr hi ack", a, 1);
    send_byte(8'h3E, a); chk(a, "R2 addr lo ack", a, 1);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk(a, "R7 data ack", a, 1);
    push(0, 12'h13E, 8'h11); push(0, 12'h13F, 8'h22); push(0, 12'h120, 8'h33);
    stop_c();
    // R6: poll during the write cycle
    start_c(); send_byte(8'hA0, a); chk(!a, "R6 busy nack", a, 0); stop_c();
    tick(BUSY + 60);
    chk(expq.size() == 0, "R7 all writes done", expq.size(), 0);
    start_c(); send_byte(8'hA0, a); chk(a, "R6 ack after cycle", a, 1); stop_c();

    // R11 R12: random + sequential read
    start_c(); send_byte(8'hA0, a); send_byte(8'h01, a); send_byte(8'h3F, a);
    start_c(); send_byte(8'hA1, a); chk(a, "R11 read select ack", a, 1);
    recv_byte(1'b0, d); chk(d == 8'h22, "R11 random data", d, 8'h22);
    recv_byte(1'b1, d); chk(d == 8'h1A, "R12 sequential next", d, 8'h1A);
    tick(H/2); chk(sda_oe == 1'b0, "R12 released after nack", sda_oe, 0);
    stop_c();

    // R11 mismatch, then R10 current reads from the loaded counter
    start_c(); send_byte(8'hA0, a); send_byte(8'h00, a); send_byte(8'h50, a);
    start_c(); send_byte(8'hA3, a); chk(!a, "R11 select mismatch nack", a, 0); stop_c();
    start_c(); send_byte(8'hA1, a); recv_byte(1'b1, d); stop_c();
    chk(d == 8'h0A, "R10 current read", d, 8'h0A);
    start_c(); send_byte(8'hA1, a); recv_byte(1'b1, d); stop_c();
    chk(d == 8'h0B, "R10 counter advanced", d, 8'h0B);

    // R7 R10: one-time page write and read wrap
    start_c(); send_byte(8'hA2, a); chk(a, "R1 page select ack", a, 1);
    send_byte(8'h00, a); send_byte(8'h1E, a);
    send_byte(8'hA1, a); send_byte(8'hB2, a); send_byte(8'hC3, a);
    push(1, 12'h01E, 8'hA1); push(1, 12'h01F, 8'hB2); push(1, 12'h000, 8'hC3);
    stop_c(); tick(BUSY + 60);
    start_c(); send_byte(8'hA2, a); send_byte(8'h00, a); send_byte(8'h1F, a);
    start_c(); send_byte(8'hA3, a);
    recv_byte(1'b0, d); chk(d == 8'hB2, "R10 page read", d, 8'hB2);
    recv_byte(1'b1, d); chk(d == 8'hC3, "R10 page wrap", d, 8'hC3);
    stop_c();

    // R9: protected write
    allow = 1'b0;
    start_c(); send_byte(8'hA0, a); chk(a, "R9 select ack", a, 1);
    send_byte(8'h02, a); send_byte(8'h10, a); chk(a, "R9 address ack", a, 1);
    send_byte(8'h77, a); chk(!a, "R9 data nack", a, 0);
    stop_c(); tick(BUSY + 60); allow = 1'b1;
    rand_read(8'hA0, 16'h0210, d); chk(d == 8'h4A, "R9 storage unchanged", d, 8'h4A);

    // R8: 33 bytes, the last refused
    start_c(); send_byte(8'hA0, a); send_byte(8'h02, a); send_byte(8'h40, a);
    for (int k = 0; k < 33; k++) begin
      send_byte(8'(k * 3 + 1), a);
      if (k < 32) begin
        push(0, 12'h240 + 12'(k), 8'(k * 3 + 1));
        if (k == 31) chk(a, "R8 32nd ack", a, 1);
      end else chk(!a, "R8 33rd nack", a, 0);
    end
    stop_c(); tick(BUSY + 60);
    chk(expq.size() == 0, "R8 page stored", expq.size(), 0);

    // R5: STOP in the middle of a byte
    start_c(); send_byte(8'hA0, a); send_byte(8'h03, a); send_byte(8'h00, a);
    send_byte(8'h99, a); chk(a, "R5 data ack", a, 1);
    send_bits(8'hF0, 4); stop_c(); tick(BUSY + 60);
    rand_read(8'hA0, 16'h0300, d); chk(d == 8'h5A, "R5 misplaced stop no write", d, 8'h5A);

    // R3: START aborts buffered bytes
    start_c(); send_byte(8'hA0, a); send_byte(8'h03, a); send_byte(8'h10, a); send_byte(8'h44, a);
    start_c(); send_byte(8'hA0, a); chk(a, "R3 restart select ack", a, 1);
    send_byte(8'h03, a); send_byte(8'h20, a); send_byte(8'h55, a);
    push(0, 12'h320, 8'h55);
    stop_c(); tick(BUSY + 60);
    rand_read(8'hA0, 16'h0310, d); chk(d == 8'h4A, "R3 aborted bytes dropped", d, 8'h4A);

    // R1: control register target
    start_c(); send_byte(8'hA8, a); chk(a, "R1 control select ack", a, 1);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h3C, a);
    push(2, 12'h000, 8'h3C);
    stop_c(); tick(BUSY + 60);
    rand_read(8'hA8, 16'h0000, d); chk(d == 8'h3C, "R1 control readback", d, 8'h3C);

    chk(expq.size() == 0, "R7 scoreboard empty", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule